// File: doc/BRIEF.md
# Multiplexed Four-Digit Hex Display Driver

This block drives a common-anode display module of four seven-segment digits whose segment lines are shared among all the digits. It takes a free-running clock, an asynchronous clear and four 4-bit characters. It turns on one digit at a time and drives the shared segment lines with the glyph for that digit's character. The scan moves to the next digit fast enough that all four digits appear lit at the same time. Every output is active low. The decimal point segment is always held dark.

A counter divides the clock into fixed slots of `SLOT_CYCLES` clocks. The default of 200 000 gives a 4 ms slot at a 50 MHz clock. Four slots then make a 16 ms frame, which is about 60 Hz and well above the rate of about 45 Hz where flicker starts to show. A four-state machine selects the digit. The states are `SLOT_D0`, `SLOT_D1`, `SLOT_D2` and `SLOT_D3`. On the last clock of each slot the machine takes the transition to the next state, and `SLOT_D3` is followed by `SLOT_D0`. Clear forces `SLOT_D0` from any state. The anode select and the segment pattern are both decoded from this one state register, so they change together on the same edge.

Top module: `hexscan_driver`

## Requirements
- R1: At all times outside clear, exactly one bit of `an_n` is 0. `an_n[i]` = 0 enables digit i, and digit 0 is the leftmost digit.
- R2: While digit i is enabled, the segments show the character `chars[4*i+3:4*i]`. A change on `chars` reaches `seg_n` in the same cycle, with no clock edge in between.
- R3: `seg_n[6:0]` = {a,b,c,d,e,f,g}, where 0 means lit. The font is: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100, A=0001000, b=1100000, C=0110001, d=1000010, E=0110000, F=0111000.
- R4: The decimal point line `seg_n[7]` is always 1, which keeps it dark.
- R5: Each digit stays enabled for exactly `SLOT_CYCLES` rising clock edges. The digit changes only on the edge that ends a slot.
- R6: Digits are scanned in the order 0, 1, 2, 3, and digit 3 is followed by digit 0.
- R7: While `clr` is high, the divider is held at zero and digit 0 is enabled at once, without waiting for a clock edge. After `clr` falls, digit 0 keeps the full first slot of `SLOT_CYCLES` edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock (50 MHz in the target system) |
| clr | input | 1 | Asynchronous clear, active high |
| chars | input | 16 | Four characters; digit i uses bits 4*i+3 to 4*i |
| seg_n | output | 8 | Segment lines, active low: bit 7 is the decimal point, bits 6 to 0 are a to g |
| an_n | output | 4 | Digit anode enables, active low, one bit per digit |

## Verification
The digit state advances on the `SLOT_CYCLES`-th rising edge after clear is released, and then on every `SLOT_CYCLES` edges after that. `an_n` and `seg_n` follow that edge with no further register in the path. A change on `chars` shows on `seg_n` with zero cycles of delay, and clear moves the display to digit 0 with no clock at all. The bench counts rising edges from the release of clear and works out the expected digit as (count / SLOT_CYCLES) mod 4. It samples only at falling edges, or a fraction of a clock after an asynchronous event, so every sample lands inside a settled cycle.

// File: rtl/hexscan_pkg.sv
`timescale 1ns/1ps
package hexscan_pkg;
    localparam int DIGITS  = 4;
    localparam int NIB_W   = 4;
    localparam int GLYPH_W = 7;
    localparam int SEG_W   = GLYPH_W + 1;

    typedef enum logic [1:0] {
        SLOT_D0 = 2'd0,
        SLOT_D1 = 2'd1,
        SLOT_D2 = 2'd2,
        SLOT_D3 = 2'd3
    } slot_e;
endpackage

// File: rtl/scan_divider.sv
`timescale 1ns/1ps
module scan_divider #(
    parameter int SLOT_CYCLES = 200_000
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

    logic [CW-1:0] count;

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            count <= '0;
        else if (count == LAST)
            count <= '0;
        else
            count <= count + 1'b1;
    end

    assign tick = (count == LAST);

    // R5: the count never leaves the slot range
    assert_count_range_R5: assert property (@(posedge clk) disable iff (clr)
        32'(count) < SLOT_CYCLES);

    // R5: between slot ends the divider steps by one
    assert_count_step_R5: assert property (@(posedge clk) disable iff (clr)
        !tick |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/digit_sequencer.sv
`timescale 1ns/1ps
module digit_sequencer
    import hexscan_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  logic              tick,
    output slot_e             slot,
    output logic [DIGITS-1:0] an_n
);
    slot_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (tick) begin
            unique case (state_q)
                SLOT_D0: state_d = SLOT_D1;
                SLOT_D1: state_d = SLOT_D2;
                SLOT_D2: state_d = SLOT_D3;
                SLOT_D3: state_d = SLOT_D0;
            endcase
        end
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            state_q <= SLOT_D0;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SLOT_D0: an_n = 4'b1110;
            SLOT_D1: an_n = 4'b1101;
            SLOT_D2: an_n = 4'b1011;
            SLOT_D3: an_n = 4'b0111;
        endcase
    end

    assign slot = state_q;

    // R5: the digit holds for the whole slot
    assert_hold_slot_R5: assert property (@(posedge clk) disable iff (clr)
        !tick |=> $stable(state_q));

    // R6: at the end of a slot the scan moves to the next digit, 3 wraps to 0
    assert_scan_order_R6: assert property (@(posedge clk) disable iff (clr)
        tick |=> (state_q == slot_e'($past(state_q) + 2'd1)));
endmodule

// File: rtl/hex_font.sv
`timescale 1ns/1ps
module hex_font
    import hexscan_pkg::*;
(
    input  logic [NIB_W-1:0]   nib,
    output logic [GLYPH_W-1:0] glyph_n
);
    always_comb begin
        unique case (nib)
            4'h0: glyph_n = 7'b0000001;
            4'h1: glyph_n = 7'b1001111;
            4'h2: glyph_n = 7'b0010010;
            4'h3: glyph_n = 7'b0000110;
            4'h4: glyph_n = 7'b1001100;
            4'h5: glyph_n = 7'b0100100;
            4'h6: glyph_n = 7'b0100000;
            4'h7: glyph_n = 7'b0001111;
            4'h8: glyph_n = 7'b0000000;
            4'h9: glyph_n = 7'b0000100;
            4'hA: glyph_n = 7'b0001000;
            4'hB: glyph_n = 7'b1100000;
            4'hC: glyph_n = 7'b0110001;
            4'hD: glyph_n = 7'b1000010;
            4'hE: glyph_n = 7'b0110000;
            4'hF: glyph_n = 7'b0111000;
        endcase
    end
endmodule

// File: rtl/hexscan_driver.sv
`timescale 1ns/1ps
module hexscan_driver
    import hexscan_pkg::*;
#(
    parameter int SLOT_CYCLES = 200_000
) (
    input  logic                    clk,
    input  logic                    clr,
    input  logic [DIGITS*NIB_W-1:0] chars,
    output logic [SEG_W-1:0]        seg_n,
    output logic [DIGITS-1:0]       an_n
);
    logic                tick;
    slot_e               slot;
    logic [NIB_W-1:0]    char_arr [DIGITS];
    logic [NIB_W-1:0]    cur_nib;
    logic [GLYPH_W-1:0]  glyph_n;

    scan_divider #(.SLOT_CYCLES(SLOT_CYCLES)) u_div (
        .clk  (clk),
        .clr  (clr),
        .tick (tick)
    );

    digit_sequencer u_seq (
        .clk  (clk),
        .clr  (clr),
        .tick (tick),
        .slot (slot),
        .an_n (an_n)
    );

    for (genvar g = 0; g < DIGITS; g++) begin : g_split
        assign char_arr[g] = chars[g*NIB_W +: NIB_W];
    end

    assign cur_nib = char_arr[slot];

    hex_font u_font (
        .nib     (cur_nib),
        .glyph_n (glyph_n)
    );

    assign seg_n = {1'b1, glyph_n};

    // R1: exactly one digit anode enabled
    assert_one_anode_R1: assert property (@(posedge clk) disable iff (clr)
        $countones(~an_n) == 1);

    // R4: decimal point stays dark
    assert_dp_dark_R4: assert property (@(posedge clk) disable iff (clr)
        seg_n[SEG_W-1] == 1'b1);

    // R2: with digit and characters unchanged, the segments do not change
    assert_seg_steady_R2: assert property (@(posedge clk) disable iff (clr)
        ($stable(an_n) && $stable(chars)) |-> $stable(seg_n));
endmodule

// File: tb/test_hexscan_driver.sv
`timescale 1ns/1ps
module test_hexscan_driver;
    localparam int SLOT  = 4;
    localparam int FRAME = 4 * SLOT;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [15:0] chars = 16'h0000;
    logic [7:0]  seg_n;
    logic [3:0]  an_n;

    always #2.5 clk = ~clk;

    hexscan_driver #(.SLOT_CYCLES(SLOT)) i_hexscan_driver (
        .clk   (clk),
        .clr   (clr),
        .chars (chars),
        .seg_n (seg_n),
        .an_n  (an_n)
    );

    // {character, expected a..g pattern, 0 = lit}
    localparam logic [10:0] VEC [16] = '{
        {4'h0, 7'b0000001}, {4'h1, 7'b1001111}, {4'h2, 7'b0010010}, {4'h3, 7'b0000110},
        {4'h4, 7'b1001100}, {4'h5, 7'b0100100}, {4'h6, 7'b0100000}, {4'h7, 7'b0001111},
        {4'h8, 7'b0000000}, {4'h9, 7'b0000100}, {4'hA, 7'b0001000}, {4'hB, 7'b1100000},
        {4'hC, 7'b0110001}, {4'hD, 7'b1000010}, {4'hE, 7'b0110000}, {4'hF, 7'b0111000}
    };

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit done   = 0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [6:0] font(input logic [3:0] v);
        logic [6:0] r;
        r = 7'bx;
        for (int k = 0; k < 16; k++)
            if (VEC[k][10:7] == v) r = VEC[k][6:0];
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        n++;
    endtask

    task automatic check_pos(input string req);
        int d;
        logic [3:0] nib;
        d   = (n / SLOT) % 4;
        nib = chars[4*d +: 4];
        chk({req, " anode"}, {4'hF, an_n}, {4'hF, ~(4'b0001 << d)});
        chk({req, " segments"}, seg_n, {1'b1, font(nib)});
    endtask

    initial begin
        // reset state, R7
        chars = 16'h1234;
        @(negedge clk);
        chk("R7 anode in clear", {4'hF, an_n}, 8'hFE);
        chk("R7 R3 segments in clear", seg_n, {1'b1, font(4'h4)});
        @(negedge clk);
        clr = 1'b0;
        n   = 0;
        check_pos("R1 R2 first digit");

        // vector table walk: every glyph in every digit position
        for (int i = 0; i < 16; i++) begin
            chars = {VEC[(i+3)%16][10:7], VEC[(i+2)%16][10:7],
                     VEC[(i+1)%16][10:7], VEC[i][10:7]};
            #1;
            check_pos("R2 change without clock");
            for (int s = 0; s < FRAME; s++) begin
                step();
                check_pos("R1 R2 R3 R4 R6 scan");
                chk("R4 dp", {7'd0, seg_n[7]}, 8'd1);
            end
        end

        // R5: slot end boundary
        chars = 16'hDCBA;
        while ((n % FRAME) != SLOT - 1) step();
        chk("R5 last cycle of slot 0", {4'hF, an_n}, 8'hFE);
        step();
        chk("R5 R6 digit 1 after slot", {4'hF, an_n}, 8'hFD);
        chk("R3 glyph b", seg_n, {1'b1, 7'b1100000});

        // R6: wrap 3 -> 0
        while ((n % FRAME) != FRAME - 1) step();
        chk("R6 digit 3", {4'hF, an_n}, 8'hF7);
        chk("R3 glyph d", seg_n, {1'b1, 7'b1000010});
        step();
        chk("R6 wrap to digit 0", {4'hF, an_n}, 8'hFE);

        // R7: asynchronous clear mid-slot, then full first slot
        while ((n % FRAME) != 2*SLOT + 1) step();
        chk("R7 in digit 2 before clear", {4'hF, an_n}, 8'hFB);
        #0.5 clr = 1'b1;
        #0.5;
        chk("R7 async clear to digit 0", {4'hF, an_n}, 8'hFE);
        @(negedge clk);
        clr = 1'b0;
        n   = 0;
        repeat (SLOT - 1) step();
        chk("R7 R5 digit 0 keeps full slot", {4'hF, an_n}, 8'hFE);
        step();
        chk("R7 R5 digit 1 after full slot", {4'hF, an_n}, 8'hFD);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule